// File: doc/BRIEF.md
# Prefetch Read Underflow Controller

This block sits between a bridge's prefetch data buffer and the target-side bus engine that returns memory-read data to the requesting master. It watches the buffer's word count and an arrival strobe. From these it decides when the first data word may be handed to the source bus, when to stall the master, and when to give up on the transaction.

Two underflow policies are available and are chosen by a one-bit mode input. The mode is sampled when a transaction opens.
- **Pair mode (mode 0).** Data return starts as soon as two words are buffered. If the buffer runs dry, the block inserts target wait states and keeps prefetching. After a bounded run of consecutive empty cycles with no new data, it requests a disconnect.
- **Line mode (mode 1).** The block holds off until a whole cache line is buffered. On the first empty cycle it stops prefetching and requests a disconnect. It then pulses a discard request for the buffered entry once the master has let go.

Top module: `prd_underflow_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with no transaction open, all five outputs are low. The captured mode resets to pair mode (0).
- R2: In pair mode (line_mode=0 when txn_active first rises), prefetch_en is high while filling. data_valid first rises in the cycle after a cycle in which buf_count >= 2.
- R3: In pair mode, a cycle during transfer with buf_count = 0 drives wait_state=1 and prefetch_en=1, with data_valid=0.
- R4: In pair mode, at most WAIT_LIMIT (default 7) consecutive wait-state cycles without a data_arrive pulse are inserted. The cycle after the last one has stop_req=1 and prefetch_en=0. A data_arrive pulse during a wait cycle restarts the count.
- R5: In line mode (line_mode=1 at transaction start), data_valid stays low until a cycle with buf_count >= LINE_WORDS has been seen, and rises in the following cycle.
- R6: In line mode, a transfer cycle with buf_count = 0 drives prefetch_en=0 and wait_state=0 in that cycle. stop_req=1 follows in the next cycle.
- R7: Once stop_req is high, the cycle in which txn_active falls is the completion cycle. In that cycle discard_entry pulses high for exactly one cycle if the transaction is in line mode, and stays low if it is in pair mode.
- R8: Changes of line_mode while a transaction is open have no effect on the start threshold or the underflow policy.
- R9: data_valid is high only when buf_count is nonzero. When txn_active falls outside a disconnect, all outputs are low in that cycle and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_active | input | 1 | A memory-read transaction is open on the source bus |
| line_mode | input | 1 | Underflow policy: 0 pair/wait, 1 full-line/discard |
| buf_count | input | CNT_W | Words currently held in the data buffer |
| data_arrive | input | 1 | A new word entered the buffer this cycle |
| data_valid | output | 1 | Buffered data may be returned to the source |
| wait_state | output | 1 | Insert a target wait state this cycle |
| stop_req | output | 1 | Request a disconnect of the source master |
| prefetch_en | output | 1 | Keep fetching from the destination bus |
| discard_entry | output | 1 | One-cycle request to drop the transaction entry and its data |

## Verification
The bench builds the block with LINE_WORDS = 4, which is a power of two and so exercises the bit-slice start comparator. This value sits well apart from the pair threshold of two, so the two start rules give visibly different results on the same counts. WAIT_LIMIT keeps its default of 7 and CNT_W its default of 5. With these values the full run of seven wait cycles is short enough to walk cycle by cycle: the bench shows the disconnect in the eighth empty cycle and shows a late arrival restarting the count.

// File: rtl/prd_pkg.sv
package prd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_XFER = 2'd2,
      ST_STOP = 2'd3
   } prd_state_e;
endpackage

// File: rtl/prd_start_gate.sv
module prd_start_gate #(
   parameter int CNT_W      = 5,
   parameter int LINE_WORDS = 8
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic             line_mode,
   output logic             start_ok
);
   localparam int LB = $clog2(LINE_WORDS);
   localparam bit LINE_POW2 = ((1 << LB) == LINE_WORDS);

   logic pair_ok;
   logic line_ok;

   assign pair_ok = |cnt[CNT_W-1:1];

   generate
      if (LINE_POW2) begin : g_slice
         assign line_ok = |cnt[CNT_W-1:LB];
      end else begin : g_cmp
         assign line_ok = (cnt >= CNT_W'(LINE_WORDS));
      end
   endgenerate

   assign start_ok = line_mode ? line_ok : pair_ok;
endmodule

// File: rtl/prd_wait_timer.sv
module prd_wait_timer #(
   parameter int WAIT_LIMIT = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_wait,
   input  logic arrive,
   output logic expire
);
   localparam int WAIT_W = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;
   localparam logic [WAIT_W-1:0] LAST = WAIT_W'(WAIT_LIMIT - 1);

   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (in_wait && !arrive && !expire) begin
         cnt_q <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   assign expire = in_wait && !arrive && (cnt_q == LAST);
endmodule

// File: rtl/prd_underflow_ctl.sv
module prd_underflow_ctl
   import prd_pkg::*;
#(
   parameter int CNT_W      = 5,
   parameter int LINE_WORDS = 8,
   parameter int WAIT_LIMIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             txn_active,
   input  logic             line_mode,
   input  logic [CNT_W-1:0] buf_count,
   input  logic             data_arrive,
   output logic             data_valid,
   output logic             wait_state,
   output logic             stop_req,
   output logic             prefetch_en,
   output logic             discard_entry
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("prd_underflow_ctl: CNT_W must be at least 2");
      end
      if (LINE_WORDS < 2 || LINE_WORDS > (1 << CNT_W) - 1) begin : g_bad_line
         $error("prd_underflow_ctl: LINE_WORDS must fit in buf_count and be at least 2");
      end
      if (WAIT_LIMIT < 1) begin : g_bad_wait
         $error("prd_underflow_ctl: WAIT_LIMIT must be at least 1");
      end
   endgenerate

   prd_state_e state_q, state_d;
   logic       mode_q;
   logic       start_ok;
   logic       expire;
   logic       empty;

   assign empty = (buf_count == '0);

   prd_start_gate #(
      .CNT_W      (CNT_W),
      .LINE_WORDS (LINE_WORDS)
   ) u_start (
      .cnt       (buf_count),
      .line_mode (mode_q),
      .start_ok  (start_ok)
   );

   prd_wait_timer #(
      .WAIT_LIMIT (WAIT_LIMIT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_wait (wait_state),
      .arrive  (data_arrive),
      .expire  (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && txn_active) begin
            mode_q <= line_mode;
         end
      end
   end

   always_comb begin
      state_d       = state_q;
      data_valid    = 1'b0;
      wait_state    = 1'b0;
      stop_req      = 1'b0;
      prefetch_en   = 1'b0;
      discard_entry = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (txn_active) state_d = ST_FILL;
         end
         ST_FILL: begin
            if (!txn_active) begin
               state_d = ST_IDLE;
            end else begin
               prefetch_en = 1'b1;
               if (start_ok) state_d = ST_XFER;
            end
         end
         ST_XFER: begin
            if (!txn_active) begin
               state_d = ST_IDLE;
            end else if (!empty) begin
               data_valid  = 1'b1;
               prefetch_en = 1'b1;
            end else if (!mode_q) begin
               wait_state  = 1'b1;
               prefetch_en = 1'b1;
               if (expire) state_d = ST_STOP;
            end else begin
               state_d = ST_STOP;
            end
         end
         ST_STOP: begin
            stop_req = 1'b1;
            if (!txn_active) begin
               discard_entry = mode_q;
               state_d       = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/prd_underflow_chk.sv
module prd_underflow_chk #(
   parameter int CNT_W      = 5,
   parameter int WAIT_LIMIT = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txn_active,
   input logic [CNT_W-1:0] buf_count,
   input logic             data_arrive,
   input logic             data_valid,
   input logic             wait_state,
   input logic             stop_req,
   input logic             prefetch_en,
   input logic             discard_entry
);
   localparam int RUN_W = $clog2(WAIT_LIMIT + 1);

   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (wait_state && !data_arrive) begin
         run_q <= run_q + 1'b1;
      end else begin
         run_q <= '0;
      end
   end

   AST_WAIT_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_state && !data_arrive) |-> (run_q < RUN_W'(WAIT_LIMIT))); // R4

   AST_WAIT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      wait_state |-> (buf_count == '0) && prefetch_en && !data_valid); // R3

   AST_DATA_NEEDS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (buf_count != '0)); // R9

   AST_STOP_HALTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> !prefetch_en && !data_valid && !wait_state); // R6

   AST_DISCARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      discard_entry |=> !discard_entry); // R7

   AST_DISCARD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      discard_entry |-> stop_req && !txn_active); // R7
endmodule

bind prd_underflow_ctl prd_underflow_chk #(
   .CNT_W      (CNT_W),
   .WAIT_LIMIT (WAIT_LIMIT)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .txn_active    (txn_active),
   .buf_count     (buf_count),
   .data_arrive   (data_arrive),
   .data_valid    (data_valid),
   .wait_state    (wait_state),
   .stop_req      (stop_req),
   .prefetch_en   (prefetch_en),
   .discard_entry (discard_entry)
);

// File: tb/prd_underflow_ctl_bench.sv
module prd_underflow_ctl_bench;
   localparam int CNT_W = 5;
   localparam int LINE  = 4;
   localparam int WLIM  = 7;
   localparam int NVEC  = 18;

   // row: txn, mode, count[4:0], arrive, expected {dv, ws, stop, pf, disc}
   localparam logic [12:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 5'd0, 1'b0, 5'b00000},  // R1 idle
      {1'b1, 1'b0, 5'd0, 1'b0, 5'b00000},  // R2 opens, still idle this cycle
      {1'b1, 1'b0, 5'd1, 1'b1, 5'b00010},  // R2 fill, one word
      {1'b1, 1'b0, 5'd2, 1'b0, 5'b00010},  // R2 pair reached
      {1'b1, 1'b0, 5'd2, 1'b0, 5'b10010},  // R2 data returned
      {1'b1, 1'b0, 5'd0, 1'b0, 5'b01010},  // R3 empty -> wait
      {1'b1, 1'b0, 5'd0, 1'b1, 5'b01010},  // R3 wait with arrival
      {1'b1, 1'b0, 5'd1, 1'b0, 5'b10010},  // R9 data again
      {1'b0, 1'b0, 5'd0, 1'b0, 5'b00000},  // R9 txn ends, outputs low
      {1'b1, 1'b1, 5'd0, 1'b0, 5'b00000},  // R5 opens in line mode
      {1'b1, 1'b0, 5'd2, 1'b0, 5'b00010},  // R8 mode flip ignored, no start at 2
      {1'b1, 1'b0, 5'd3, 1'b0, 5'b00010},  // R5 still filling
      {1'b1, 1'b0, 5'd4, 1'b0, 5'b00010},  // R5 line reached
      {1'b1, 1'b0, 5'd3, 1'b0, 5'b10010},  // R5 data returned
      {1'b1, 1'b0, 5'd0, 1'b0, 5'b00000},  // R6 empty: fetch off, no wait
      {1'b1, 1'b0, 5'd0, 1'b0, 5'b00100},  // R6 stop
      {1'b0, 1'b0, 5'd0, 1'b0, 5'b00101},  // R7 release -> discard
      {1'b0, 1'b0, 5'd0, 1'b0, 5'b00000}   // R7 discard gone
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             txn_active = 1'b0;
   logic             line_mode = 1'b0;
   logic [CNT_W-1:0] buf_count = '0;
   logic             data_arrive = 1'b0;
   logic             data_valid, wait_state, stop_req, prefetch_en, discard_entry;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prd_underflow_ctl #(
      .CNT_W      (CNT_W),
      .LINE_WORDS (LINE),
      .WAIT_LIMIT (WLIM)
   ) u_prd_underflow_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .txn_active    (txn_active),
      .line_mode     (line_mode),
      .buf_count     (buf_count),
      .data_arrive   (data_arrive),
      .data_valid    (data_valid),
      .wait_state    (wait_state),
      .stop_req      (stop_req),
      .prefetch_en   (prefetch_en),
      .discard_entry (discard_entry)
   );

   task automatic drive(input logic t, input logic m, input logic [CNT_W-1:0] c, input logic a);
      @(posedge clk);
      #1;
      txn_active  = t;
      line_mode   = m;
      buf_count   = c;
      data_arrive = a;
      #3;
   endtask

   task automatic expect_out(input logic [4:0] exp, input string tag);
      logic [4:0] act;
      act = {data_valid, wait_state, stop_req, prefetch_en, discard_entry};
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: outputs {dv,ws,stop,pf,disc} = %b, expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input logic t, input logic m, input logic [CNT_W-1:0] c,
                       input logic a, input logic [4:0] exp, input string tag);
      drive(t, m, c, a);
      expect_out(exp, tag);
   endtask

   initial begin
      #4;
      expect_out(5'b00000, "R1 in reset");
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][12], VEC[i][11], VEC[i][10:6], VEC[i][5]);
         expect_out(VEC[i][4:0], $sformatf("vector %0d (R1..R9 table)", i));
      end

      // R4: seven waits, arrival on the seventh restarts, seven more, then stop
      step(1, 0, 0, 0, 5'b00000, "R4 open");
      step(1, 0, 2, 0, 5'b00010, "R4 fill");
      step(1, 0, 2, 0, 5'b10010, "R4 data");
      for (int k = 0; k < WLIM - 1; k++) step(1, 0, 0, 0, 5'b01010, "R4 wait run");
      step(1, 0, 0, 1, 5'b01010, "R4 wait with arrival");
      for (int k = 0; k < WLIM; k++) step(1, 1, 0, 0, 5'b01010, "R4 restarted run");
      step(1, 0, 0, 0, 5'b00100, "R4 limit -> stop");
      step(0, 0, 0, 0, 5'b00100, "R7 pair mode release, no discard");
      step(0, 0, 0, 0, 5'b00000, "R9 back to idle");

      // R1: reset in the middle of a transfer
      step(1, 0, 0, 0, 5'b00000, "R1 open");
      step(1, 0, 3, 0, 5'b00010, "R1 fill");
      step(1, 0, 3, 0, 5'b10010, "R1 data");
      #1 rst_n = 1'b0;
      #1 expect_out(5'b00000, "R1 async reset");
      @(posedge clk);
      #1 rst_n = 1'b1;
      step(0, 0, 0, 0, 5'b00000, "R1 after reset idle");
      // R1: mode resets to pair: opening with mode 0 starts at two words
      step(1, 0, 0, 0, 5'b00000, "R1 open");
      step(1, 0, 2, 0, 5'b00010, "R1 fill");
      step(1, 0, 2, 0, 5'b10010, "R1 pair start");
      step(0, 0, 0, 0, 5'b00000, "R9 close");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule